// File: doc/BRIEF.md
# Dual-User Memory Port Router

This block sits in the data path between two 16-bit user ports and one memory-side bus that holds 16 data bits and 6 or 8 check bits. A user can store a word in memory. The word passes through a SEC-DED encoder on the way out. A user can also fetch a word from memory. That word passes through the matching decoder, which can correct a single flipped bit or only detect it. The two users can also hand a word straight to each other without touching memory. When one user works with memory, the other user can watch the same word on its own port if its listen input is high.

Each user presents a request as a valid/ready stream: `valid`, an operation code and the write word. User 1 always wins, so its `ready` is constantly high. User 2 sees `ready` low in any cycle in which user 1 has `valid` high. While `valid` is high and `ready` is low, user 2 must hold `valid`, `op` and `wdata` stable. The transfer happens in the cycle where `valid` and `ready` are both high.

The result side has no back-pressure. A port's `rdata` is meaningful only in the cycle where its `oe` is high. Memory must return the read word on `mem_rdata` in the same cycle that `mem_re` is high, because the path is flow-through. The error flags for a memory read are registered and appear in the following cycle, so the system can react to them.

Top module: `dual_port_router`

## Requirements
- R1: User 1's `u1_ready` is always 1. `u2_ready` equals the inverse of `u1_valid`, so in a cycle where both users request, user 1's request is the one carried out and user 2 waits.
- R2: The op codes are 2'b00 memory write, 2'b01 memory read, 2'b10 send to the other user, and 2'b11 reserved. A granted reserved request raises no enable, and the flags are 0 in the next cycle.
- R3: On a granted memory write, `mem_we` is 1 and `mem_wdata[15:0]` is the writer's word. The check bits are in `mem_wdata[CODE_W-1:16]`. `mem_wdata` is all zeros whenever `mem_we` is 0.
- R4: On a granted memory read of an unaltered codeword that this block wrote, `mem_re` is 1, the reader's `oe` is 1 and its `rdata` is the original word. Both flags are 0 in the next cycle.
- R5: With `correct_en`=1, flipping any one of the CODE_W codeword bits gives the original word on the reader's `rdata`. In the next cycle `err_single` is 1 and `err_multi` is 0.
- R6: With `correct_en`=0, a single flipped bit is not repaired. The reader's `rdata` is `mem_rdata[15:0]` and `err_single` is still 1 in the next cycle.
- R7: Flipping any two codeword bits gives `err_multi`=1 and `err_single`=0 in the next cycle. The reader's `rdata` is the raw `mem_rdata[15:0]`.
- R8: On a send to the other user, the receiver's `oe` is 1 and its `rdata` is the sender's word. `mem_we` and `mem_re` stay 0, and both flags are 0 in the next cycle.
- R9: During a memory access by one user, the other port's `oe` follows its listen input. When the other port listens, it shows the write word or the decoded read word, and the owner's own results are unchanged.
- R10: `mem_we` and `mem_re` are never 1 together. A user's `oe` is never 1 while that user's own write or send is being carried out.
- R11: The flags are registered one cycle after the access, are never 1 together, and are forced to 0 at once by `rst_n`=0.
- R12: With no `valid` high, all enables are 0 and both `rdata` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| correct_en | input | 1 | 1: repair single-bit errors; 0: detect only |
| u1_valid | input | 1 | User 1 request valid |
| u1_op | input | 2 | User 1 operation code |
| u1_wdata | input | DATA_W | User 1 outgoing word |
| u1_listen | input | 1 | User 1 wants copies of user 2 memory traffic |
| u1_ready | output | 1 | User 1 request accepted |
| u1_oe | output | 1 | Router drives user 1 port this cycle |
| u1_rdata | output | DATA_W | Word delivered to user 1 |
| u2_valid | input | 1 | User 2 request valid |
| u2_op | input | 2 | User 2 operation code |
| u2_wdata | input | DATA_W | User 2 outgoing word |
| u2_listen | input | 1 | User 2 wants copies of user 1 memory traffic |
| u2_ready | output | 1 | User 2 request accepted (low = wait) |
| u2_oe | output | 1 | Router drives user 2 port this cycle |
| u2_rdata | output | DATA_W | Word delivered to user 2 |
| mem_we | output | 1 | Memory write strobe / memory bus driven |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | CODE_W | Codeword to memory |
| mem_rdata | input | CODE_W | Codeword from memory, same cycle as `mem_re` |
| err_single | output | 1 | Previous read held a single-bit error |
| err_multi | output | 1 | Previous read held an uncorrectable error |

## Verification
The hardest case to reach from the ports is a read of a valid codeword with chosen bits flipped. The check bits are not visible at the ports unless a write produces them. The bench therefore first performs a memory write and captures the codeword from `mem_wdata`. It then presents that word back on `mem_rdata` with every single bit and a sweep of adjacent and extreme bit pairs flipped. The expected data is the original word, so no encoder is needed in the bench. A second hard situation is a registered error flag that is still pending while the next cycle is a user-to-user send. The bench creates it by issuing a faulty read followed at once by a send, and checks both the flag's arrival and its clearing.

// File: rtl/dur_pkg.sv
`timescale 1ns/1ps
package dur_pkg;

  typedef enum logic [1:0] {
    OP_MEM_WR = 2'b00,
    OP_MEM_RD = 2'b01,
    OP_PEER   = 2'b10,
    OP_NONE   = 2'b11
  } op_e;

  // Number of Hamming check bits needed to cover dw data bits.
  function automatic int ham_bits(input int dw);
    int res = 0;
    for (int r = 1; r < 32; r++)
      if (res == 0 && (1 << r) >= dw + r + 1) res = r;
    return res;
  endfunction

  // Codeword position (1-based, skipping powers of two) of data bit j.
  function automatic int data_pos(input int j);
    int cnt = 0;
    int res = 0;
    for (int q = 3; q < 128; q++)
      if ((q & (q - 1)) != 0) begin
        if (cnt == j && res == 0) res = q;
        cnt++;
      end
    return res;
  endfunction

endpackage

// File: rtl/secded_enc.sv
`timescale 1ns/1ps
module secded_enc import dur_pkg::*; #(
  parameter int DATA_W  = 16,
  parameter int CHECK_W = 6
) (
  input  logic [DATA_W-1:0]  data_i,
  output logic [CHECK_W-1:0] check_o
);
  localparam int HAM_W   = ham_bits(DATA_W);
  localparam int EXTRA_W = CHECK_W - HAM_W - 1;
  localparam int SLICE_W = DATA_W / ((EXTRA_W > 0) ? EXTRA_W : 1);

  logic [HAM_W-1:0] ham;

  always_comb begin
    ham = '0;
    for (int j = 0; j < DATA_W; j++)
      for (int k = 0; k < HAM_W; k++)
        if (((data_pos(j) >> k) & 1) == 1) ham[k] = ham[k] ^ data_i[j];
  end

  assign check_o[HAM_W-1:0] = ham;
  assign check_o[HAM_W]     = ^{data_i, ham};

  // Optional slice parities when the wider check field is chosen.
  for (genvar e = 0; e < EXTRA_W; e++) begin : g_slice
    assign check_o[HAM_W+1+e] = ^data_i[e*SLICE_W +: SLICE_W];
  end
endmodule

// File: rtl/secded_dec.sv
`timescale 1ns/1ps
module secded_dec import dur_pkg::*; #(
  parameter int DATA_W  = 16,
  parameter int CHECK_W = 6
) (
  input  logic [DATA_W+CHECK_W-1:0] code_i,
  input  logic                      correct_en_i,
  output logic [DATA_W-1:0]         data_o,
  output logic                      err_single_o,
  output logic                      err_multi_o
);
  localparam int HAM_W   = ham_bits(DATA_W);
  localparam int EXTRA_W = CHECK_W - HAM_W - 1;
  localparam int CODE_W  = DATA_W + CHECK_W;
  localparam int MAX_POS = DATA_W + HAM_W;

  logic [CHECK_W-1:0] recalc;
  logic [HAM_W-1:0]   syn;
  logic [DATA_W-1:0]  flip;
  logic               ovr, syn_ok, extra_bad, single;

  secded_enc #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_recalc (
    .data_i (code_i[DATA_W-1:0]),
    .check_o(recalc)
  );

  assign syn    = recalc[HAM_W-1:0] ^ code_i[DATA_W +: HAM_W];
  // parity over all received SEC-DED bits, rebuilt from the recomputed parity
  assign ovr    = recalc[HAM_W] ^ code_i[DATA_W+HAM_W] ^ (^syn);
  assign syn_ok = int'(syn) <= MAX_POS;

  if (EXTRA_W > 0) begin : g_xb
    assign extra_bad = |(recalc[CHECK_W-1:HAM_W+1] ^ code_i[CODE_W-1:DATA_W+HAM_W+1]);
  end else begin : g_nxb
    assign extra_bad = 1'b0;
  end

  always_comb begin
    for (int j = 0; j < DATA_W; j++)
      flip[j] = (int'(syn) == data_pos(j));
  end

  assign single       = ovr && syn_ok;
  assign err_single_o = single;
  assign err_multi_o  = (ovr && !syn_ok) || (!ovr && syn != '0) ||
                        (!ovr && syn == '0 && extra_bad);
  assign data_o       = (single && correct_en_i) ? (code_i[DATA_W-1:0] ^ flip)
                                                 : code_i[DATA_W-1:0];
endmodule

// File: rtl/port_route.sv
`timescale 1ns/1ps
module port_route import dur_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       u1_valid,
  input  logic [1:0] u1_op,
  input  logic       u2_valid,
  input  logic [1:0] u2_op,
  input  logic       u1_listen,
  input  logic       u2_listen,
  output logic       u1_ready,
  output logic       u2_ready,
  output logic       own2,
  output logic       mem_we,
  output logic       mem_re,
  output logic       u1_oe,
  output logic       u2_oe
);
  logic act, peer, mem_any;
  op_e  op_sel;

  assign u1_ready = 1'b1;
  assign u2_ready = !u1_valid;
  assign own2     = u2_valid && !u1_valid;
  assign act      = u1_valid || u2_valid;
  assign op_sel   = own2 ? op_e'(u2_op) : op_e'(u1_op);

  assign mem_we  = act && (op_sel == OP_MEM_WR);
  assign mem_re  = act && (op_sel == OP_MEM_RD);
  assign peer    = act && (op_sel == OP_PEER);
  assign mem_any = mem_we || mem_re;

  assign u1_oe = own2 ? (peer || (u1_listen && mem_any)) : mem_re;
  assign u2_oe = own2 ? mem_re : (u1_valid && (peer || (u2_listen && mem_any)));

  AST_U2_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (u1_valid && u2_valid) |-> !u2_ready); // R1
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (u1_valid && u1_op == 2'b11) |-> (!mem_we && !mem_re && !u1_oe && !u2_oe)); // R2
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R10
  AST_OWNER_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (u1_valid && (u1_op == 2'b00 || u1_op == 2'b10)) |-> !u1_oe); // R10
  AST_LISTEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (u1_valid && !u2_listen && u1_op != 2'b10) |-> !u2_oe); // R9
endmodule

// File: rtl/dual_port_router.sv
`timescale 1ns/1ps
module dual_port_router import dur_pkg::*; #(
  parameter int DATA_W  = 16,
  parameter int CHECK_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      correct_en,
  input  logic                      u1_valid,
  input  logic [1:0]                u1_op,
  input  logic [DATA_W-1:0]         u1_wdata,
  input  logic                      u1_listen,
  output logic                      u1_ready,
  output logic                      u1_oe,
  output logic [DATA_W-1:0]         u1_rdata,
  input  logic                      u2_valid,
  input  logic [1:0]                u2_op,
  input  logic [DATA_W-1:0]         u2_wdata,
  input  logic                      u2_listen,
  output logic                      u2_ready,
  output logic                      u2_oe,
  output logic [DATA_W-1:0]         u2_rdata,
  output logic                      mem_we,
  output logic                      mem_re,
  output logic [DATA_W+CHECK_W-1:0] mem_wdata,
  input  logic [DATA_W+CHECK_W-1:0] mem_rdata,
  output logic                      err_single,
  output logic                      err_multi
);
  localparam int CODE_W = DATA_W + CHECK_W;

  logic               own2;
  logic [DATA_W-1:0]  src_word, dec_word;
  logic [CHECK_W-1:0] enc_check;
  logic               dec_single, dec_multi;

  port_route u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .u1_valid (u1_valid),
    .u1_op    (u1_op),
    .u2_valid (u2_valid),
    .u2_op    (u2_op),
    .u1_listen(u1_listen),
    .u2_listen(u2_listen),
    .u1_ready (u1_ready),
    .u2_ready (u2_ready),
    .own2     (own2),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .u1_oe    (u1_oe),
    .u2_oe    (u2_oe)
  );

  assign src_word = own2 ? u2_wdata : u1_wdata;

  secded_enc #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_enc (
    .data_i (src_word),
    .check_o(enc_check)
  );

  secded_dec #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_dec (
    .code_i      (mem_rdata),
    .correct_en_i(correct_en),
    .data_o      (dec_word),
    .err_single_o(dec_single),
    .err_multi_o (dec_multi)
  );

  assign mem_wdata = mem_we ? {enc_check, src_word} : {CODE_W{1'b0}};
  assign u1_rdata  = !u1_oe ? '0 : (mem_re ? dec_word : u2_wdata);
  assign u2_rdata  = !u2_oe ? '0 : (mem_re ? dec_word : u1_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_single <= 1'b0;
      err_multi  <= 1'b0;
    end else begin
      err_single <= mem_re && dec_single;
      err_multi  <= mem_re && dec_multi;
    end
  end

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_single && err_multi)); // R11
  AST_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (err_single || err_multi) |-> $past(mem_re)); // R11
  AST_PEER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (u1_valid && u1_op == 2'b10) |=> (!err_single && !err_multi)); // R8
  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!u1_valid && !u2_valid) |-> (!mem_we && !mem_re && !u1_oe && !u2_oe
                                  && u1_rdata == '0 && u2_rdata == '0)); // R12
  AST_WDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> (mem_wdata == '0)); // R3
endmodule

// File: tb/dual_port_router_tb_top.sv
`timescale 1ns/1ps
module dual_port_router_tb_top;
  localparam int DW     = 16;
  localparam int CW     = 6;
  localparam int CODE_W = DW + CW;
  localparam logic [1:0] WR = 2'b00, RD = 2'b01, PX = 2'b10, RSV = 2'b11;

  // {u1v,u1op,u2v,u2op,l1,l2} _ {r1,r2,we,re,oe1,oe2}
  localparam int NV = 15;
  localparam logic [13:0] VEC [NV] = '{
    14'b00000000_110000, 14'b10000000_101000, 14'b10000001_101001,
    14'b10100000_100110, 14'b10100001_100111, 14'b11000000_100001,
    14'b00010010_111010, 14'b00010100_110101, 14'b00011000_110010,
    14'b11100000_100000, 14'b10010101_101001, 14'b10111000_100110,
    14'b00011110_110000, 14'b11010000_100001, 14'b00010110_110111
  };

  logic clk = 1'b0, rst_n = 1'b0, correct_en = 1'b1;
  logic u1_valid, u1_listen, u1_ready, u1_oe, u2_valid, u2_listen, u2_ready, u2_oe;
  logic [1:0] u1_op, u2_op;
  logic [DW-1:0] u1_wdata, u2_wdata, u1_rdata, u2_rdata;
  logic mem_we, mem_re, err_single, err_multi;
  logic [CODE_W-1:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dual_port_router #(.DATA_W(DW), .CHECK_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .correct_en(correct_en),
    .u1_valid(u1_valid), .u1_op(u1_op), .u1_wdata(u1_wdata), .u1_listen(u1_listen),
    .u1_ready(u1_ready), .u1_oe(u1_oe), .u1_rdata(u1_rdata),
    .u2_valid(u2_valid), .u2_op(u2_op), .u2_wdata(u2_wdata), .u2_listen(u2_listen),
    .u2_ready(u2_ready), .u2_oe(u2_oe), .u2_rdata(u2_rdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .err_single(err_single), .err_multi(err_multi)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v1, input logic [1:0] o1, input logic [DW-1:0] d1,
                       input logic v2, input logic [1:0] o2, input logic [DW-1:0] d2,
                       input logic l1, input logic l2, input logic [CODE_W-1:0] mrd);
    @(negedge clk);
    u1_valid = v1; u1_op = o1; u1_wdata = d1;
    u2_valid = v2; u2_op = o2; u2_wdata = d2;
    u1_listen = l1; u2_listen = l2; mem_rdata = mrd;
    #5;
  endtask

  task automatic flags_next(input logic es, input logic em, input string req);
    drive(1'b0, WR, '0, 1'b0, WR, '0, 1'b0, 1'b0, '0);
    chk(err_single == es && err_multi == em, req, {30'd0, err_single, err_multi}, {30'd0, es, em});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d1, d2;
    logic [CODE_W-1:0] cw, cw2, word;
    logic [5:0] got;
    u1_valid = 0; u1_op = WR; u1_wdata = '0; u1_listen = 0;
    u2_valid = 0; u2_op = WR; u2_wdata = '0; u2_listen = 0; mem_rdata = '0;
    d1 = 16'hB4E1; d2 = 16'h7F02;

    // reset state (R11, R12)
    repeat (3) @(posedge clk);
    @(negedge clk); #5;
    chk(!err_single && !err_multi, "R11 reset flags", {30'd0, err_single, err_multi}, 0);
    chk({mem_we, mem_re, u1_oe, u2_oe} == 4'b0 && u1_rdata == 0 && u2_rdata == 0,
        "R12 idle outputs", {mem_we, mem_re, u1_oe, u2_oe, u1_rdata, u2_rdata[11:0]}, 0);
    rst_n = 1'b1;

    // vector table: handshake and enables (R1 R2 R9 R10)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13], VEC[i][12:11], d1, VEC[i][10], VEC[i][9:8], d2,
            VEC[i][7], VEC[i][6], '0);
      got = {u1_ready, u2_ready, mem_we, mem_re, u1_oe, u2_oe};
      chk(got == VEC[i][5:0], "R1 R2 R9 R10 table", {26'd0, got}, {26'd0, VEC[i][5:0]});
    end

    // R3 write layout, capture codeword
    drive(1, WR, d1, 0, WR, '0, 0, 0, '0);
    cw = mem_wdata;
    chk(mem_we && cw[DW-1:0] == d1, "R3 write data field", {16'd0, cw[DW-1:0]}, {16'd0, d1});
    chk(!u1_oe, "R10 writer port undriven", {31'd0, u1_oe}, 0);

    // R4 clean read
    drive(1, RD, '0, 0, WR, '0, 0, 0, cw);
    chk(u1_oe && u1_rdata == d1, "R4 clean read", {16'd0, u1_rdata}, {16'd0, d1});
    flags_next(0, 0, "R4 no flags");

    // R5 every single flip corrected
    for (int b = 0; b < CODE_W; b++) begin
      word = cw ^ (CODE_W'(1) << b);
      drive(1, RD, '0, 0, WR, '0, 0, 0, word);
      chk(u1_rdata == d1, "R5 single corrected", {16'd0, u1_rdata}, {16'd0, d1});
      flags_next(1, 0, "R5 single flag");
    end

    // R7 double flips
    for (int b = 0; b < CODE_W - 1; b++) begin
      word = cw ^ (CODE_W'(3) << b);
      drive(1, RD, '0, 0, WR, '0, 0, 0, word);
      chk(u1_rdata == word[DW-1:0], "R7 double raw data", {16'd0, u1_rdata}, {16'd0, word[DW-1:0]});
      flags_next(0, 1, "R7 double flag");
    end
    word = cw ^ {1'b1, {(CODE_W-2){1'b0}}, 1'b1};
    drive(1, RD, '0, 0, WR, '0, 0, 0, word);
    flags_next(0, 1, "R7 extreme pair");

    // R6 detect-only mode
    correct_en = 1'b0;
    drive(1, RD, '0, 0, WR, '0, 0, 0, cw ^ CODE_W'(8));
    chk(u1_rdata == (d1 ^ 16'h0008), "R6 raw data kept", {16'd0, u1_rdata}, {16'd0, d1 ^ 16'h0008});
    flags_next(1, 0, "R6 single flagged");
    correct_en = 1'b1;

    // R9 listening on read and write; owner unaffected
    drive(1, RD, '0, 0, WR, '0, 0, 1, cw ^ (CODE_W'(1) << 9));
    chk(u2_oe && u2_rdata == d1, "R9 listener read copy", {16'd0, u2_rdata}, {16'd0, d1});
    chk(u1_rdata == d1, "R9 owner read intact", {16'd0, u1_rdata}, {16'd0, d1});
    drive(1, WR, d1, 0, WR, '0, 0, 1, '0);
    chk(u2_oe && u2_rdata == d1 && mem_wdata == cw, "R9 listener write copy",
        {16'd0, u2_rdata}, {16'd0, d1});
    drive(1, WR, d1, 0, WR, '0, 0, 0, '0);
    chk(!u2_oe && u2_rdata == 0, "R9 listen off", {15'd0, u2_oe, u2_rdata}, 0);

    // R4 user 2 round trip with user 1 listening
    drive(0, WR, '0, 1, WR, d2, 0, 0, '0);
    cw2 = mem_wdata;
    chk(cw2[DW-1:0] == d2, "R3 user2 write", {16'd0, cw2[DW-1:0]}, {16'd0, d2});
    drive(0, WR, '0, 1, RD, '0, 1, 0, cw2);
    chk(u2_rdata == d2 && u1_rdata == d2, "R4 user2 read", {u1_rdata, u2_rdata}, {d2, d2});

    // R8 send after faulty read: pending flag seen, then cleared (R11)
    drive(1, RD, '0, 0, WR, '0, 0, 0, cw ^ CODE_W'(2));
    drive(1, PX, 16'h1234, 0, WR, '0, 0, 0, cw ^ CODE_W'(3));
    chk(u2_oe && u2_rdata == 16'h1234 && !mem_we && !mem_re, "R8 peer 1 to 2",
        {15'd0, u2_oe, u2_rdata}, {15'd1, 16'h1234});
    chk(err_single, "R11 flag one cycle late", {31'd0, err_single}, 1);
    flags_next(0, 0, "R8 flags low after send");
    drive(0, WR, '0, 1, PX, d2, 0, 0, '0);
    chk(u1_oe && u1_rdata == d2, "R8 peer 2 to 1", {16'd0, u1_rdata}, {16'd0, d2});

    // R1 user 2 held then served
    drive(1, WR, d1, 1, PX, d2, 0, 0, '0);
    chk(!u2_ready && !u1_oe, "R1 user2 waits", {30'd0, u2_ready, u1_oe}, 0);
    drive(0, WR, '0, 1, PX, d2, 0, 0, '0);
    chk(u2_ready && u1_rdata == d2, "R1 user2 served", {15'd0, u2_ready, u1_rdata}, {15'd1, d2});

    // R2 reserved op ignored even with bad memory word
    drive(1, RSV, d1, 0, WR, '0, 0, 1, cw ^ CODE_W'(3));
    chk({mem_we, mem_re, u1_oe, u2_oe} == 4'b0 && mem_wdata == 0, "R2 reserved quiet",
        {28'd0, mem_we, mem_re, u1_oe, u2_oe}, 0);
    flags_next(0, 0, "R2 reserved no flags");

    // R11 asynchronous reset clears a set flag
    drive(1, RD, '0, 0, WR, '0, 0, 0, cw ^ CODE_W'(3));
    @(negedge clk);
    u1_valid = 0; rst_n = 1'b0;
    #5;
    chk(!err_multi && !err_single, "R11 reset clears flag", {30'd0, err_single, err_multi}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end
endmodule